// File: doc/BRIEF.md
# Host-to-SPI Flash Window Decoder

This block sits between a host bus front end, which has already parsed LPC and firmware-hub memory cycles, and an SPI command engine. For each memory request it checks whether the 32-bit host address lies inside a programmable flash window. If it does, it converts the address to a 24-bit flash address, chooses a flash instruction and hands one request at a time to the SPI engine. While that request is outstanding it asks the host bus for long waits, and when the engine acknowledges it answers with a one-cycle sync completion.

The window starts at a 16-bit base value placed in the upper half of the host address, with the lower half zero. A 3-bit size code sets the length. The flash address is the host address minus the window start, so the base does not need to be aligned to the window length. Reads always go straight to the flash. Writes go to the flash only when direct write transfer is enabled. Otherwise they set a sticky flag for firmware and complete at once. Cycles outside the window, or with a transfer size the cycle type does not allow, get no answer at all.

Top module: `flash_window_bridge`

## Requirements
- R1: A request hits when base <= addr[31:16] < base + (16 << cfg_size), with cfg_size in 0..4 giving 1, 2, 4, 8 or 16 MB. A cfg_size above 4 never hits.
- R2: On a hit, spi_addr is ({addr[31:16] - base, addr[15:0]}) cut to 24 bits.
- R3: A miss starts no SPI request, raises no sync and leaves the firmware flag unchanged.
- R4: req_size encodes 0 = byte, 1 = word and 2 = longword. Code 3 is illegal, and an LPC request (req_fwh = 0) with a size other than byte is also illegal. An illegal request is treated like a miss.
- R5: A read hit always goes to the SPI engine with instruction 0x03, or 0x0B when cfg_fast_read = 1, whatever cfg_direct_wr_en is set to.
- R6: A write hit with cfg_direct_wr_en = 1 goes to the SPI engine with instruction 0x02, or 0xAD when cfg_aai_mode = 1. spi_wdata carries req_wdata.
- R7: A write hit with cfg_direct_wr_en = 0 starts no SPI request. It sets fw_trap_flag and pulses host_sync in the cycle after acceptance. fw_trap_flag stays set until fw_flag_clr, and a new trap wins over a clear in the same cycle.
- R8: From the cycle after acceptance until spi_ack, spi_req and host_long_wait are high and the request payload stays stable.
- R9: host_sync pulses for exactly one cycle, in the cycle after spi_ack is sampled. For reads, host_rdata then holds the spi_rdata value seen with the acknowledge.
- R10: spi_count equals the transfer size in bytes: 1, 2 or 4.
- R11: A req_valid while a request is being served is ignored.
- R12: After reset, spi_req, host_long_wait, host_sync and fw_trap_flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | 16 | Window start, upper 16 address bits |
| cfg_size | input | 3 | Window size code |
| cfg_direct_wr_en | input | 1 | Enable direct write transfer to flash |
| cfg_fast_read | input | 1 | Use fast read instruction |
| cfg_aai_mode | input | 1 | Use auto-increment program for writes |
| fw_flag_clr | input | 1 | Clear firmware trap flag |
| req_valid | input | 1 | Memory request strobe, one cycle |
| req_addr | input | 32 | Host address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fwh | input | 1 | 1 = firmware-hub cycle, 0 = LPC cycle |
| req_size | input | 2 | Transfer size code |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| host_long_wait | output | 1 | Host should insert long waits |
| host_sync | output | 1 | Completion pulse |
| host_rdata | output | 32 | Read data returned |
| fw_trap_flag | output | 1 | Write waiting for firmware handling |
| spi_req | output | 1 | Request to SPI engine |
| spi_instr | output | 8 | Flash instruction code |
| spi_addr | output | 24 | Flash address |
| spi_count | output | 3 | Byte count |
| spi_wdata | output | 32 | Program data |
| spi_ack | input | 1 | SPI engine done |
| spi_rdata | input | 32 | Data read from flash |

## Verification
The assertions take for granted that the front end sends one request and then waits for its completion, and that spi_ack is only raised while spi_req is high. The SPI engine model in the bench acknowledges each request exactly once, after a random delay. The bench also injects a req_valid during a busy period on purpose, to show it is ignored. The configuration is changed only between requests, so the value seen at acceptance is the one that sets the instruction and address.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DONE} seq_state_t;

  localparam logic [7:0] OP_READ      = 8'h03;
  localparam logic [7:0] OP_FAST_READ = 8'h0B;
  localparam logic [7:0] OP_PROGRAM   = 8'h02;
  localparam logic [7:0] OP_AAI       = 8'hAD;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  // Window length in 64 KB units: 16 << size_code
  function automatic logic [16:0] win_units(input logic [2:0] code);
    return 17'd16 << code;
  endfunction

  function automatic logic [2:0] byte_count(input logic [1:0] code);
    return 3'd1 << code;
  endfunction

  function automatic logic [7:0] pick_op(input logic wr, input logic fast,
                                         input logic aai);
    if (wr) return aai ? OP_AAI : OP_PROGRAM;
    return fast ? OP_FAST_READ : OP_READ;
  endfunction
endpackage

// File: rtl/fwb_window_map.sv
module fwb_window_map #(
  parameter int HA_W = 32,
  parameter int FA_W = 24,
  parameter int MAX_SIZE_CODE = 4,
  localparam int HALF = HA_W / 2
) (
  input  logic [HALF-1:0] base,
  input  logic [2:0]      size_code,
  input  logic [HA_W-1:0] addr,
  output logic            hit,
  output logic [FA_W-1:0] faddr
);
  import fwb_pkg::*;

  logic [HALF:0] offset;
  logic [HA_W-1:0] full;
  logic [16:0] limit;

  always_comb begin
    offset = {1'b0, addr[HA_W-1:HALF]} - {1'b0, base};
    limit  = win_units(size_code);
    hit    = !offset[HALF] && (int'(size_code) <= MAX_SIZE_CODE)
             && ({1'b0, offset[HALF-1:0]} < limit);
    full   = {offset[HALF-1:0], addr[HALF-1:0]};
    faddr  = full[FA_W-1:0];
  end
endmodule

// File: rtl/fwb_cmd_select.sv
module fwb_cmd_select (
  input  logic       write,
  input  logic       fwh,
  input  logic [1:0] size,
  input  logic       direct_wr_en,
  input  logic       fast_read,
  input  logic       aai_mode,
  output logic       size_ok,
  output logic       to_spi,
  output logic       to_fw,
  output logic [7:0] instr,
  output logic [2:0] count
);
  import fwb_pkg::*;

  always_comb begin
    size_ok = (size != 2'd3) && (fwh || size == SZ_BYTE);
    to_spi  = !write || direct_wr_en;
    to_fw   = write && !direct_wr_en;
    instr   = pick_op(write, fast_read, aai_mode);
    count   = byte_count(size);
  end
endmodule

// File: rtl/fwb_seq.sv
module fwb_seq #(
  parameter int FA_W = 24,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            accept_ok,
  input  logic            to_spi,
  input  logic            to_fw,
  input  logic [7:0]      instr_in,
  input  logic [FA_W-1:0] addr_in,
  input  logic [2:0]      count_in,
  input  logic [DW-1:0]   wdata_in,
  input  logic            is_read,
  input  logic            flag_clr,
  input  logic            spi_ack,
  input  logic [DW-1:0]   spi_rdata,
  output logic            take,
  output logic            fwd_evt,
  output logic            trap_evt,
  output logic            spi_req,
  output logic [7:0]      spi_instr,
  output logic [FA_W-1:0] spi_addr,
  output logic [2:0]      spi_count,
  output logic [DW-1:0]   spi_wdata,
  output logic            long_wait,
  output logic            sync,
  output logic [DW-1:0]   rdata,
  output logic            trap_flag
);
  import fwb_pkg::*;

  seq_state_t state;
  logic       rd_pending;

  assign take      = req_valid && (state == ST_IDLE);
  assign fwd_evt   = take && accept_ok && to_spi;
  assign trap_evt  = take && accept_ok && to_fw;
  assign spi_req   = (state == ST_ISSUE);
  assign long_wait = (state == ST_ISSUE);
  assign sync      = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      spi_instr  <= '0;
      spi_addr   <= '0;
      spi_count  <= '0;
      spi_wdata  <= '0;
      rdata      <= '0;
      rd_pending <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fwd_evt) begin
            state      <= ST_ISSUE;
            spi_instr  <= instr_in;
            spi_addr   <= addr_in;
            spi_count  <= count_in;
            spi_wdata  <= wdata_in;
            rd_pending <= is_read;
          end else if (trap_evt) begin
            state <= ST_DONE;
          end
        end
        ST_ISSUE: begin
          if (spi_ack) begin
            state <= ST_DONE;
            if (rd_pending) rdata <= spi_rdata;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trap_flag <= 1'b0;
    else if (trap_evt) trap_flag <= 1'b1;
    else if (flag_clr) trap_flag <= 1'b0;
  end
endmodule

// File: rtl/flash_window_bridge.sv
module flash_window_bridge #(
  parameter int HA_W = 32,
  parameter int FA_W = 24,
  parameter int DW = 32,
  parameter int MAX_SIZE_CODE = 4,
  localparam int HALF = HA_W / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HALF-1:0] cfg_base,
  input  logic [2:0]      cfg_size,
  input  logic            cfg_direct_wr_en,
  input  logic            cfg_fast_read,
  input  logic            cfg_aai_mode,
  input  logic            fw_flag_clr,
  input  logic            req_valid,
  input  logic [HA_W-1:0] req_addr,
  input  logic            req_write,
  input  logic            req_fwh,
  input  logic [1:0]      req_size,
  input  logic [DW-1:0]   req_wdata,
  output logic            host_long_wait,
  output logic            host_sync,
  output logic [DW-1:0]   host_rdata,
  output logic            fw_trap_flag,
  output logic            spi_req,
  output logic [7:0]      spi_instr,
  output logic [FA_W-1:0] spi_addr,
  output logic [2:0]      spi_count,
  output logic [DW-1:0]   spi_wdata,
  input  logic            spi_ack,
  input  logic [DW-1:0]   spi_rdata
);
  logic            win_hit;
  logic [FA_W-1:0] win_faddr;
  logic            size_ok, to_spi, to_fw;
  logic [7:0]      sel_instr;
  logic [2:0]      sel_count;
  logic            accept_ok;
  logic            req_take, fwd_evt, trap_evt;

  fwb_window_map #(.HA_W(HA_W), .FA_W(FA_W), .MAX_SIZE_CODE(MAX_SIZE_CODE)) u_map (
    .base(cfg_base), .size_code(cfg_size), .addr(req_addr),
    .hit(win_hit), .faddr(win_faddr)
  );

  fwb_cmd_select u_sel (
    .write(req_write), .fwh(req_fwh), .size(req_size),
    .direct_wr_en(cfg_direct_wr_en), .fast_read(cfg_fast_read),
    .aai_mode(cfg_aai_mode), .size_ok(size_ok), .to_spi(to_spi),
    .to_fw(to_fw), .instr(sel_instr), .count(sel_count)
  );

  assign accept_ok = win_hit && size_ok;

  fwb_seq #(.FA_W(FA_W), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .accept_ok(accept_ok),
    .to_spi(to_spi), .to_fw(to_fw), .instr_in(sel_instr), .addr_in(win_faddr),
    .count_in(sel_count), .wdata_in(req_wdata), .is_read(!req_write),
    .flag_clr(fw_flag_clr), .spi_ack(spi_ack), .spi_rdata(spi_rdata),
    .take(req_take), .fwd_evt(fwd_evt), .trap_evt(trap_evt),
    .spi_req(spi_req), .spi_instr(spi_instr), .spi_addr(spi_addr),
    .spi_count(spi_count), .spi_wdata(spi_wdata), .long_wait(host_long_wait),
    .sync(host_sync), .rdata(host_rdata), .trap_flag(fw_trap_flag)
  );
endmodule

// File: rtl/fwb_checker.sv
module fwb_checker #(
  parameter int FA_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_take,
  input logic            accept_ok,
  input logic            trap_evt,
  input logic            fw_trap_flag,
  input logic            spi_req,
  input logic            spi_ack,
  input logic [7:0]      spi_instr,
  input logic [FA_W-1:0] spi_addr,
  input logic [2:0]      spi_count,
  input logic            host_long_wait,
  input logic            host_sync
);
  AST_NO_START_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && !accept_ok) |=> (!spi_req && !host_sync)); // R3
  AST_MISS_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && !accept_ok && !fw_trap_flag) |=> !fw_trap_flag); // R3
  AST_TRAP_SYNC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_evt |=> (host_sync && !spi_req && fw_trap_flag)); // R7
  AST_WAIT_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> host_long_wait); // R8
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_addr) && $stable(spi_instr)
                               && $stable(spi_count))); // R8
  AST_SYNC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && spi_ack) |=> (host_sync && !spi_req)); // R9
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_sync |=> !host_sync); // R9
  AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> $onehot0(spi_count) && (spi_count != 3'd0)); // R10
  AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spi_req, host_sync})); // R11
endmodule

bind flash_window_bridge fwb_checker #(.FA_W(FA_W)) u_fwb_checker (
  .clk(clk), .rst_n(rst_n), .req_take(req_take), .accept_ok(accept_ok),
  .trap_evt(trap_evt), .fw_trap_flag(fw_trap_flag), .spi_req(spi_req),
  .spi_ack(spi_ack), .spi_instr(spi_instr), .spi_addr(spi_addr),
  .spi_count(spi_count), .host_long_wait(host_long_wait), .host_sync(host_sync)
);

// File: tb/flash_window_bridge_test.sv
module flash_window_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_base = '0;
  logic [2:0]  cfg_size = '0;
  logic cfg_direct_wr_en = 1'b0, cfg_fast_read = 1'b0, cfg_aai_mode = 1'b0;
  logic fw_flag_clr = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_write = 1'b0, req_fwh = 1'b0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic host_long_wait, host_sync, fw_trap_flag, spi_req;
  logic [31:0] host_rdata, spi_wdata;
  logic [7:0] spi_instr;
  logic [23:0] spi_addr;
  logic [2:0] spi_count;
  logic spi_ack = 1'b0;
  logic [31:0] spi_rdata = '0;

  int n_tests = 0;
  int n_fail = 0;
  bit flag_model = 1'b0;

  always #5 clk = ~clk;

  flash_window_bridge uut (.*);

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ref_hit(input logic [15:0] b, input logic [2:0] s, input logic [31:0] a,
                                 input logic fwh, input logic [1:0] sz);
    int hi, lim;
    hi = int'(a[31:16]);
    if (s > 3'd4) return 1'b0;
    if (sz == 2'd3) return 1'b0;
    if (!fwh && sz != 2'd0) return 1'b0;
    lim = 16 * (2 ** int'(s));
    return (hi >= int'(b)) && (hi < int'(b) + lim);
  endfunction

  function automatic logic [23:0] ref_faddr(input logic [15:0] b, input logic [31:0] a);
    int diff;
    diff = int'(a[31:16]) - int'(b);
    return {diff[7:0], a[15:0]};
  endfunction

  function automatic logic [7:0] ref_op(input logic wr, input logic fast, input logic aai);
    if (wr) return aai ? 8'hAD : 8'h02;
    return fast ? 8'h0B : 8'h03;
  endfunction

  // One host transaction; bench drives on negedge and samples on negedge
  task automatic run_cycle(input logic [31:0] a, input logic wr, input logic fwh,
                           input logic [1:0] sz, input int ack_delay, input bit inject);
    bit hit, fwd;
    logic [31:0] wd, rd;
    wd = $urandom;
    rd = $urandom;
    hit = ref_hit(cfg_base, cfg_size, a, fwh, sz);
    fwd = hit && (!wr || cfg_direct_wr_en);
    @(negedge clk);
    req_addr = a; req_write = wr; req_fwh = fwh; req_size = sz; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!hit) begin
      for (int i = 0; i < 6; i++) begin
        check("R3/R4 miss: no spi_req", spi_req == 1'b0, spi_req, 0);
        check("R3/R4 miss: no sync", host_sync == 1'b0, host_sync, 0);
        check("R3 miss: flag unchanged", fw_trap_flag == flag_model, fw_trap_flag, flag_model);
        @(negedge clk);
      end
    end else if (!fwd) begin
      flag_model = 1'b1;
      check("R7 trap: sync next cycle", host_sync == 1'b1, host_sync, 1);
      check("R7 trap: no spi_req", spi_req == 1'b0, spi_req, 0);
      check("R7 trap: flag set", fw_trap_flag == 1'b1, fw_trap_flag, 1);
      @(negedge clk);
      check("R9 sync one cycle", host_sync == 1'b0, host_sync, 0);
    end else begin
      check("R8 spi_req raised", spi_req == 1'b1, spi_req, 1);
      check("R2 flash address", spi_addr == ref_faddr(cfg_base, a), spi_addr, ref_faddr(cfg_base, a));
      check(wr ? "R6 write instr" : "R5 read instr",
            spi_instr == ref_op(wr, cfg_fast_read, cfg_aai_mode), spi_instr,
            ref_op(wr, cfg_fast_read, cfg_aai_mode));
      check("R10 byte count", spi_count == (3'd1 << sz), spi_count, 3'd1 << sz);
      if (wr) check("R6 write data", spi_wdata == wd, spi_wdata, wd);
      for (int i = 0; i < ack_delay; i++) begin
        if (inject && i == 0) begin
          req_addr = ~a; req_write = ~wr; req_valid = 1'b1;
          @(negedge clk);
          req_valid = 1'b0;
          check("R11 busy request ignored", spi_addr == ref_faddr(cfg_base, a),
                spi_addr, ref_faddr(cfg_base, a));
        end else @(negedge clk);
        check("R8 long wait held", host_long_wait == 1'b1 && spi_req == 1'b1, host_long_wait, 1);
        check("R8 payload stable", spi_addr == ref_faddr(cfg_base, a), spi_addr, ref_faddr(cfg_base, a));
      end
      spi_rdata = rd; spi_ack = 1'b1;
      @(negedge clk);
      spi_ack = 1'b0;
      check("R9 sync after ack", host_sync == 1'b1, host_sync, 1);
      check("R9 spi_req dropped", spi_req == 1'b0 && host_long_wait == 1'b0, spi_req, 0);
      if (!wr) check("R9 read data", host_rdata == rd, host_rdata, rd);
      @(negedge clk);
      check("R9 sync one cycle", host_sync == 1'b0, host_sync, 0);
      check("R11 no second request", spi_req == 1'b0, spi_req, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R12 reset spi_req", spi_req == 1'b0, spi_req, 0);
    check("R12 reset long wait", host_long_wait == 1'b0, host_long_wait, 0);
    check("R12 reset sync", host_sync == 1'b0, host_sync, 0);
    check("R12 reset flag", fw_trap_flag == 1'b0, fw_trap_flag, 0);
    rst_n = 1'b1;

    // Directed: 1 MB window at 0x231F, edges
    cfg_base = 16'h231F; cfg_size = 3'd0; cfg_direct_wr_en = 1'b0;
    run_cycle(32'h231F_0000, 1'b0, 1'b0, 2'd0, 2, 1'b0);  // R1 lower edge, R5 read with direct off
    run_cycle(32'h232E_FFFF, 1'b0, 1'b1, 2'd2, 1, 1'b0);  // R1 upper edge
    run_cycle(32'h232F_0000, 1'b0, 1'b1, 2'd0, 1, 1'b0);  // R1 just past end
    run_cycle(32'h231E_FFFF, 1'b0, 1'b1, 2'd0, 1, 1'b0);  // R1 just below base
    run_cycle(32'h2320_0000, 1'b0, 1'b0, 2'd1, 1, 1'b0);  // R4 LPC word illegal
    run_cycle(32'h2320_0000, 1'b0, 1'b1, 2'd3, 1, 1'b0);  // R4 size code 3
    run_cycle(32'h2320_1234, 1'b1, 1'b1, 2'd1, 1, 1'b0);  // R7 trap
    @(negedge clk); fw_flag_clr = 1'b1;
    @(negedge clk); fw_flag_clr = 1'b0; flag_model = 1'b0;
    check("R7 flag cleared", fw_trap_flag == 1'b0, fw_trap_flag, 0);
    cfg_size = 3'd5;
    run_cycle(32'h231F_0000, 1'b0, 1'b1, 2'd0, 1, 1'b0);  // R1 size above 4
    cfg_size = 3'd4; cfg_direct_wr_en = 1'b1; cfg_aai_mode = 1'b1;
    run_cycle(32'h241E_ABCD, 1'b1, 1'b1, 2'd2, 3, 1'b1);  // R6 AAI, R11 inject
    cfg_base = 16'hFFF0; cfg_size = 3'd0;
    run_cycle(32'hFFFF_FFFF, 1'b0, 1'b1, 2'd0, 1, 1'b0);  // R1 top of host space

    // Random mix
    for (int t = 0; t < 400; t++) begin
      logic [31:0] a;
      logic [15:0] off;
      cfg_base = (t % 3 == 0) ? 16'($urandom) : 16'h1000 + 16'($urandom_range(0, 255));
      cfg_size = 3'($urandom_range(0, 5));
      cfg_direct_wr_en = 1'($urandom); cfg_fast_read = 1'($urandom);
      cfg_aai_mode = 1'($urandom);
      off = 16'($urandom_range(0, 300)) - 16'd8;
      a = {cfg_base + off, 16'($urandom)};
      if (t % 5 == 0) a = $urandom;
      run_cycle(a, 1'($urandom), 1'($urandom), 2'($urandom_range(0, 3)),
                $urandom_range(0, 4), (t % 7) == 0);
      if (fw_trap_flag && (t % 4 == 0)) begin
        @(negedge clk); fw_flag_clr = 1'b1;
        @(negedge clk); fw_flag_clr = 1'b0; flag_model = 1'b0;
        check("R7 flag cleared", fw_trap_flag == 1'b0, fw_trap_flag, 0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule